// File: doc/BRIEF.md
# Transaction Response Tracker

This block sits on the requester side of a packet link. It watches every request the local issuer hands to the link and keeps track of the ones that expect a reply. Reads and non-posted writes each take one tag from a small pool. The tag is released when the matching reply comes back. Posted writes never take a tag and are never held back. The tracker only counts them until the link reports each one as sent.

Replies come in on a response port. Each reply is matched against the outstanding tag table. Read data is handed back to the issuer together with its tag and status, in the order the replies arrive. A reply that names a tag that is not in use, or whose kind does not fit the request held under that tag, is dropped and sets a sticky error flag.

Producer/consumer ordering is kept by fencing reads behind posted writes. A read issued while earlier posted writes are still unsent has its data reply refused until all of those writes have been sent. An idle output tells a power controller when the link has fully drained.

Top module: `txn_resp_tracker`

## Requirements
- R1: A request with `reqKind` = 2'b01 (posted write) sees `reqReady` high in every cycle, even with every tag in use. It takes no tag and adds one to the count of unsent posted writes. A `postSent` pulse removes one from that count; a pulse while the count is zero has no effect.
- R2: A request with `reqKind` = 2'b00 (read) or 2'b10 (non-posted write) is given the lowest-numbered free tag, shown on `reqTag` in the accepting cycle. With all `NUM_TAGS` tags busy, `reqReady` is low for these kinds. `reqKind` = 2'b11 takes no tag and has no effect.
- R3: A non-posted write's tag stays busy until a reply with `rspKind` = 1 (done) carrying that tag is accepted. No read data is produced for it.
- R4: A reply with `rspKind` = 0 (data) that matches an outstanding read is accepted. One cycle after acceptance, `rdValid` is high for one cycle with `rdTag`, `rdData` and `rdStatus` equal to the reply's tag, data and status.
- R5: Read results leave in the order their replies are accepted, whatever the order the reads were issued in.
- R6: A read issued while N posted writes are unsent gets `rspReady` low for its data reply until N `postSent` pulses have been registered. A pulse in the same cycle as the reply does not release it; the reply is accepted from the next cycle on.
- R7: A reply whose tag is not busy, or whose kind does not match the request under that tag, is accepted (`rspReady` high) and dropped. It produces no read result, leaves the tag table unchanged, and sets `errFlag` from the next cycle until reset.
- R8: A second reply to a tag that has already been completed counts as an unexpected reply under R7.
- R9: `idle` is high exactly when no tag is busy and no posted write is unsent.
- R10: A tag freed by a reply accepted in one cycle is not offered in that cycle. It can be handed out again from the next cycle.
- R11: After reset, all tags are free, the posted count is zero, `idle` is high, `errFlag` and `rdValid` are low, and `reqReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Issuer presents a request |
| reqKind | input | 2 | 00 read, 01 posted write, 10 non-posted write, 11 no-op |
| reqReady | output | 1 | Request is taken this cycle |
| reqTag | output | TAG_W | Tag given to a tagged request (lowest free tag) |
| postSent | input | 1 | Link has sent one posted write |
| rspValid | input | 1 | Reply present |
| rspKind | input | 1 | 0 read data, 1 done |
| rspTag | input | TAG_W | Tag carried by the reply |
| rspData | input | DATA_W | Read data carried by the reply |
| rspStatus | input | STAT_W | Reply status |
| rspReady | output | 1 | Reply is taken this cycle |
| rdValid | output | 1 | Read result valid |
| rdTag | output | TAG_W | Tag of the read result |
| rdData | output | DATA_W | Read result data |
| rdStatus | output | STAT_W | Read result status |
| errFlag | output | 1 | Sticky unexpected-reply flag |
| idle | output | 1 | Nothing outstanding, nothing unsent |

## Verification
Two pairs of events can meet in one cycle, and the bench drives both on purpose.

The first pair is a reply that frees a tag and a request that wants a tag. The bench fills the pool, then presents a read request together with a reply for tag 6. It expects `reqReady` low in that cycle, and `reqReady` high with tag 6 offered in the next.

The second pair is a `postSent` pulse and a held, fenced read reply. The bench expects the reply still refused in the pulse cycle and accepted in the following one, with the read result appearing one cycle after acceptance.

// File: rtl/txnTrkPkg.sv
package txnTrkPkg;
  localparam logic [1:0] REQ_READ   = 2'b00;
  localparam logic [1:0] REQ_POSTED = 2'b01;
  localparam logic [1:0] REQ_NPWR   = 2'b10;

  localparam logic RSP_DATA = 1'b0;
  localparam logic RSP_DONE = 1'b1;

  // strobes from the control to the datapath
  typedef struct packed {
    logic deliver;  // matched read reply accepted this cycle
    logic flagErr;  // unexpected reply accepted this cycle
  } trkStrbT;
endpackage

// File: rtl/txn_trk_ctrl.sv
module txn_trk_ctrl
  import txnTrkPkg::*;
#(
  parameter int NUM_TAGS   = 8,
  parameter int POST_CNT_W = 6,
  localparam int TAG_W     = $clog2(NUM_TAGS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [1:0]       reqKind,
  output logic             reqReady,
  output logic [TAG_W-1:0] reqTag,
  input  logic             postSent,
  input  logic             rspValid,
  input  logic             rspKind,
  input  logic [TAG_W-1:0] rspTag,
  output logic             rspReady,
  output logic             idle,
  output trkStrbT          strb
);
  logic [NUM_TAGS-1:0]   busy;
  logic [NUM_TAGS-1:0]   isRd;
  logic [POST_CNT_W-1:0] waitCnt [NUM_TAGS];
  logic [POST_CNT_W-1:0] postPend;

  logic [TAG_W-1:0] freeTag;
  logic             anyFree;
  logic             needTag, alloc, postIn, sentNow;
  logic             tagMatch, hold, accept, freeIt;

  // lowest-numbered free tag
  always_comb begin
    freeTag = '0;
    anyFree = 1'b0;
    for (int i = NUM_TAGS - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        freeTag = TAG_W'(i);
        anyFree = 1'b1;
      end
    end
  end

  assign needTag  = (reqKind == REQ_READ) || (reqKind == REQ_NPWR);
  assign reqReady = needTag ? anyFree : 1'b1;
  assign reqTag   = freeTag;
  assign alloc    = reqValid && needTag && anyFree;
  assign postIn   = reqValid && (reqKind == REQ_POSTED);
  assign sentNow  = postSent && (postPend != '0);

  // reply matching and read fencing
  assign tagMatch = busy[rspTag] && (isRd[rspTag] == (rspKind == RSP_DATA));
  assign hold     = rspValid && tagMatch && isRd[rspTag] && (waitCnt[rspTag] != '0);
  assign rspReady = !hold;
  assign accept   = rspValid && !hold;
  assign freeIt   = accept && tagMatch;

  assign strb.deliver = freeIt && isRd[rspTag];
  assign strb.flagErr = accept && !tagMatch;

  assign idle = (busy == '0) && (postPend == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      postPend <= '0;
    end else if (postIn && !sentNow) begin
      postPend <= postPend + 1'b1;
    end else if (!postIn && sentNow) begin
      postPend <= postPend - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= '0;
      isRd <= '0;
      for (int i = 0; i < NUM_TAGS; i++) waitCnt[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_TAGS; i++) begin
        if (alloc && (freeTag == TAG_W'(i))) begin
          busy[i]    <= 1'b1;
          isRd[i]    <= (reqKind == REQ_READ);
          waitCnt[i] <= (reqKind == REQ_READ) ? (postPend - POST_CNT_W'(sentNow)) : '0;
        end else begin
          if (freeIt && (rspTag == TAG_W'(i))) busy[i] <= 1'b0;
          if (sentNow && (waitCnt[i] != '0)) waitCnt[i] <= waitCnt[i] - 1'b1;
        end
      end
    end
  end

  // R2
  alloc_tag_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && needTag) |-> !busy[reqTag]);

  // R3
  done_frees_tag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspReady && rspKind == RSP_DONE && busy[rspTag] && !isRd[rspTag])
      |=> !busy[$past(rspTag)]);

  // R1
  post_no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (postIn && !postSent) |-> (postPend != '1));

  // R9
  idle_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(idle) |-> $past(rspValid || postSent));
endmodule

// File: rtl/txn_trk_dpath.sv
module txn_trk_dpath
  import txnTrkPkg::*;
#(
  parameter int TAG_W  = 3,
  parameter int DATA_W = 32,
  parameter int STAT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  trkStrbT           strb,
  input  logic [TAG_W-1:0]  rspTag,
  input  logic [DATA_W-1:0] rspData,
  input  logic [STAT_W-1:0] rspStatus,
  output logic              rdValid,
  output logic [TAG_W-1:0]  rdTag,
  output logic [DATA_W-1:0] rdData,
  output logic [STAT_W-1:0] rdStatus,
  output logic              errFlag
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid  <= 1'b0;
      rdTag    <= '0;
      rdData   <= '0;
      rdStatus <= '0;
      errFlag  <= 1'b0;
    end else begin
      rdValid <= strb.deliver;
      if (strb.deliver) begin
        rdTag    <= rspTag;
        rdData   <= rspData;
        rdStatus <= rspStatus;
      end
      if (strb.flagErr) errFlag <= 1'b1;
    end
  end

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);
endmodule

// File: rtl/txn_resp_tracker.sv
module txn_resp_tracker
  import txnTrkPkg::*;
#(
  parameter int NUM_TAGS   = 8,
  parameter int DATA_W     = 32,
  parameter int STAT_W     = 2,
  parameter int POST_CNT_W = 6,
  localparam int TAG_W     = $clog2(NUM_TAGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  output logic              reqReady,
  output logic [TAG_W-1:0]  reqTag,
  input  logic              postSent,
  input  logic              rspValid,
  input  logic              rspKind,
  input  logic [TAG_W-1:0]  rspTag,
  input  logic [DATA_W-1:0] rspData,
  input  logic [STAT_W-1:0] rspStatus,
  output logic              rspReady,
  output logic              rdValid,
  output logic [TAG_W-1:0]  rdTag,
  output logic [DATA_W-1:0] rdData,
  output logic [STAT_W-1:0] rdStatus,
  output logic              errFlag,
  output logic              idle
);
  trkStrbT strb;

  txn_trk_ctrl #(
    .NUM_TAGS  (NUM_TAGS),
    .POST_CNT_W(POST_CNT_W)
  ) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqKind (reqKind),
    .reqReady(reqReady),
    .reqTag  (reqTag),
    .postSent(postSent),
    .rspValid(rspValid),
    .rspKind (rspKind),
    .rspTag  (rspTag),
    .rspReady(rspReady),
    .idle    (idle),
    .strb    (strb)
  );

  txn_trk_dpath #(
    .TAG_W (TAG_W),
    .DATA_W(DATA_W),
    .STAT_W(STAT_W)
  ) i_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .rspTag   (rspTag),
    .rspData  (rspData),
    .rspStatus(rspStatus),
    .rdValid  (rdValid),
    .rdTag    (rdTag),
    .rdData   (rdData),
    .rdStatus (rdStatus),
    .errFlag  (errFlag)
  );

  // R4
  rd_follows_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(rspValid && rspReady && rspKind == RSP_DATA));
endmodule

// File: tb/test_txn_resp_tracker.sv
module test_txn_resp_tracker;
  localparam int DATA_W = 32;
  localparam int TAG_W  = 3;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic [1:0]        reqKind = 2'b00;
  logic              reqReady;
  logic [TAG_W-1:0]  reqTag;
  logic              postSent = 1'b0;
  logic              rspValid = 1'b0;
  logic              rspKind = 1'b0;
  logic [TAG_W-1:0]  rspTag = '0;
  logic [DATA_W-1:0] rspData = '0;
  logic [1:0]        rspStatus = '0;
  logic              rspReady;
  logic              rdValid;
  logic [TAG_W-1:0]  rdTag;
  logic [DATA_W-1:0] rdData;
  logic [1:0]        rdStatus;
  logic              errFlag;
  logic              idle;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  txn_resp_tracker i_txn_resp_tracker (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqReady(reqReady), .reqTag(reqTag), .postSent(postSent),
    .rspValid(rspValid), .rspKind(rspKind), .rspTag(rspTag),
    .rspData(rspData), .rspStatus(rspStatus), .rspReady(rspReady),
    .rdValid(rdValid), .rdTag(rdTag), .rdData(rdData), .rdStatus(rdStatus),
    .errFlag(errFlag), .idle(idle)
  );

  // stimulus {rqV,rqK,rsV,rsK,rsT,rsD,ps} expected {rdy,tag,rsRdy,idle,rdV,err}
  localparam int NV = 11;
  localparam logic [24:0] TBL [NV] = '{
    {1'b1,2'b00,1'b0,1'b0,3'd0,8'h00,1'b0, 1'b1,3'd0,1'b1,1'b0,1'b0,1'b0}, // R2 read tag0
    {1'b1,2'b01,1'b0,1'b0,3'd0,8'h00,1'b0, 1'b1,3'd1,1'b1,1'b0,1'b0,1'b0}, // R1 posted
    {1'b1,2'b00,1'b0,1'b0,3'd0,8'h00,1'b0, 1'b1,3'd1,1'b1,1'b0,1'b0,1'b0}, // R2 fenced read tag1
    {1'b1,2'b10,1'b0,1'b0,3'd0,8'h00,1'b0, 1'b1,3'd2,1'b1,1'b0,1'b0,1'b0}, // R2 np write tag2
    {1'b0,2'b00,1'b1,1'b0,3'd1,8'h00,1'b0, 1'b1,3'd3,1'b0,1'b0,1'b0,1'b0}, // R6 held
    {1'b0,2'b00,1'b1,1'b0,3'd0,8'h11,1'b0, 1'b1,3'd3,1'b1,1'b0,1'b1,1'b0}, // R4 R5 tag0
    {1'b0,2'b00,1'b1,1'b0,3'd1,8'h00,1'b1, 1'b1,3'd0,1'b0,1'b0,1'b0,1'b0}, // R6 pulse cycle
    {1'b0,2'b00,1'b1,1'b0,3'd1,8'h22,1'b0, 1'b1,3'd0,1'b1,1'b0,1'b1,1'b0}, // R6 released
    {1'b0,2'b00,1'b1,1'b1,3'd2,8'h00,1'b0, 1'b1,3'd0,1'b1,1'b1,1'b0,1'b0}, // R3 R9 done
    {1'b0,2'b00,1'b1,1'b1,3'd2,8'h00,1'b0, 1'b1,3'd0,1'b1,1'b1,1'b0,1'b1}, // R8 duplicate
    {1'b0,2'b00,1'b0,1'b0,3'd0,8'h00,1'b0, 1'b1,3'd0,1'b1,1'b1,1'b0,1'b1}  // R7 sticky
  };

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic setIn(input logic rqV, input logic [1:0] rqK, input logic rsV,
                       input logic rsK, input logic [2:0] rsT, input logic [31:0] rsD,
                       input logic ps);
    reqValid = rqV; reqKind = rqK; rspValid = rsV; rspKind = rsK;
    rspTag = rsT; rspData = rsD; postSent = ps;
  endtask

  task automatic doReset();
    setIn(1'b0, 2'b00, 1'b0, 1'b0, 3'd0, 32'd0, 1'b0);
    rspStatus = 2'b00;
    rstN = 1'b0;
    tick();
    tick();
    rstN = 1'b1;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    doReset();
    // R11 reset state
    #1;
    chk("R11 idle", idle, 1);
    chk("R11 errFlag", errFlag, 0);
    chk("R11 rdValid", rdValid, 0);
    chk("R11 reqReady", reqReady, 1);

    // vector table
    for (int v = 0; v < NV; v++) begin
      logic [24:0] e;
      e = TBL[v];
      setIn(e[24], e[23:22], e[21], e[20], e[19:17], {24'd0, e[16:9]}, e[8]);
      #1;
      chk($sformatf("R2 row%0d reqReady", v), reqReady, e[7]);
      chk($sformatf("R2 row%0d reqTag", v), reqTag, e[6:4]);
      chk($sformatf("R6 row%0d rspReady", v), rspReady, e[3]);
      tick();
      chk($sformatf("R9 row%0d idle", v), idle, e[2]);
      chk($sformatf("R4 row%0d rdValid", v), rdValid, e[1]);
      chk($sformatf("R7 row%0d errFlag", v), errFlag, e[0]);
      if (v == 5) chk("R5 first data", rdData, 32'h11);
      if (v == 7) chk("R5 second data", rdData, 32'h22);
    end

    // R2 fill the pool, R1 posted while full
    doReset();
    #1;
    for (int i = 0; i < 8; i++) begin
      setIn(1'b1, 2'b00, 1'b0, 1'b0, 3'd0, 32'd0, 1'b0);
      #1;
      chk("R2 fill tag", reqTag, i);
      tick();
    end
    setIn(1'b1, 2'b00, 1'b0, 1'b0, 3'd0, 32'd0, 1'b0);
    #1;
    chk("R2 full read refused", reqReady, 0);
    reqKind = 2'b10;
    #1;
    chk("R2 full np refused", reqReady, 0);
    reqKind = 2'b01;
    #1;
    chk("R1 posted while full", reqReady, 1);
    tick();
    chk("R9 not idle", idle, 0);

    // R10 reply frees tag 6 while a read waits
    setIn(1'b1, 2'b00, 1'b1, 1'b0, 3'd6, 32'hA6, 1'b0);
    rspStatus = 2'b10;
    #1;
    chk("R10 same cycle refused", reqReady, 0);
    chk("R4 rspReady", rspReady, 1);
    tick();
    chk("R4 rdValid", rdValid, 1);
    chk("R4 rdTag", rdTag, 6);
    chk("R4 rdData", rdData, 32'hA6);
    chk("R4 rdStatus", rdStatus, 2'b10);
    setIn(1'b1, 2'b00, 1'b0, 1'b0, 3'd0, 32'd0, 1'b0);
    #1;
    chk("R10 next cycle ready", reqReady, 1);
    chk("R10 next cycle tag", reqTag, 6);

    // R5 replies out of issue order
    setIn(1'b0, 2'b00, 1'b1, 1'b0, 3'd5, 32'h55, 1'b0);
    rspStatus = 2'b01;
    tick();
    chk("R5 first tag", rdTag, 5);
    setIn(1'b0, 2'b00, 1'b1, 1'b0, 3'd2, 32'h22, 1'b0);
    tick();
    chk("R5 second tag", rdTag, 2);
    chk("R5 second data", rdData, 32'h22);
    chk("R5 no error", errFlag, 0);

    // R1 posted drained, tags still busy
    setIn(1'b0, 2'b00, 1'b0, 1'b0, 3'd0, 32'd0, 1'b1);
    tick();
    setIn(1'b0, 2'b00, 1'b0, 1'b0, 3'd0, 32'd0, 1'b0);
    #1;
    chk("R9 busy tags keep not idle", idle, 0);

    // R7 kind mismatch is dropped and leaves the tag busy
    setIn(1'b0, 2'b00, 1'b1, 1'b1, 3'd0, 32'd0, 1'b0);
    #1;
    chk("R7 mismatch accepted", rspReady, 1);
    tick();
    chk("R7 mismatch error", errFlag, 1);
    chk("R7 mismatch no data", rdValid, 0);
    setIn(1'b0, 2'b00, 1'b1, 1'b0, 3'd0, 32'h0A, 1'b0);
    tick();
    chk("R7 tag kept busy", rdValid, 1);
    chk("R7 tag kept data", rdData, 32'h0A);

    // R7 reply to an unused tag
    doReset();
    setIn(1'b0, 2'b00, 1'b1, 1'b0, 3'd3, 32'h33, 1'b0);
    tick();
    chk("R7 unused tag error", errFlag, 1);
    chk("R7 unused tag no data", rdValid, 0);
    chk("R7 unused tag idle", idle, 1);
    setIn(1'b0, 2'b00, 1'b0, 1'b0, 3'd0, 32'd0, 1'b0);
    tick();
    chk("R7 error sticky", errFlag, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule